// File: doc/BRIEF.md
# Sticky Fault Register with Machine-Error Request

This block collects error conditions into a 16-flag sticky register. Eleven active-low fault pins and a small group of active-high internal fault sources are sampled on every rising edge of the sync clock. Any flag that is captured stays set until a single clear command wipes the whole register; no flag can be cleared alone.

The first capture after a clear raises a machine-error request toward interrupt level 1. The request stays up until the service routine acknowledges it with a clear pulse. After that acknowledge, no further request is produced, however many new faults arrive, until the register has been cleared again.

The protection-violation pin is routed to one of two flags, depending on whether the processor or a DMA device owns the memory cycle. The processor-side flag is not captured while either acknowledge line shows a DMA or hold grant. When the processor-side flag becomes set, the block drives a one-cycle active-low abort toward the instruction sequencer.

Top module: `fault_latch_unit`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, `fault_reg` reads all zeros, `lvl1_req` is 0 and `abort_n` is 1.
- R2: Pin mapping is as follows. A low on `fault_pin_n[k]` for k from 1 to 10 sets `fault_reg[k+1]`, so pin 1 (memory parity) sets bit 2 and pin 2 (I/O parity) sets bit 3. A high on `int_fault[j]` sets `fault_reg[12+j]`. A level sampled at one rising edge appears in `fault_reg` right after that edge.
- R3: A set flag stays set after its source returns inactive. Only `clr_faults` clears flags, and it clears all of them at once.
- R4: A low on `fault_pin_n[0]` sets bit 1 when `dma_cycle` is 1. It sets bit 0 when `dma_cycle` is 0.
- R5: Bit 0 is not set while `dma_ack_n` or `hold_ack_n` is low. Bit 1 is not affected by these two lines.
- R6: Once the register is nonzero and the block is armed, `lvl1_req` rises one cycle after the register first becomes nonzero. It stays high until a `lvl1_clr` pulse.
- R7: After `lvl1_clr`, new faults do not raise `lvl1_req` again. A `clr_faults` re-arms the block, so the next fault raises a new request.
- R8: A fault sampled in the same cycle as `clr_faults` is kept in the register after the clear, and it raises a new request.
- R9: `abort_n` is low for exactly one cycle, in the cycle when bit 0 goes from clear to set. It does not pulse for other bits, and it does not pulse while bit 0 is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock |
| rst | input | 1 | Synchronous reset, active high |
| fault_pin_n | input | 11 | Fault pins, active low; pin 0 is the protection fault |
| int_fault | input | 4 | Internal fault sources, active high |
| dma_cycle | input | 1 | Current memory cycle is owned by a DMA device |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| hold_ack_n | input | 1 | Hold acknowledge, active low |
| clr_faults | input | 1 | Clear the whole fault register and re-arm |
| lvl1_clr | input | 1 | Acknowledge from the service routine, drops the request |
| fault_reg | output | 16 | Sticky fault flags |
| lvl1_req | output | 1 | Level-1 machine-error request |
| abort_n | output | 1 | One-cycle active-low abort of the executing instruction |

## Verification
The assertions assume that `clr_faults` and `lvl1_clr` are single-cycle pulses. They also assume that a fault pin held low across a clear is intended as a new fault. The abort-width property is therefore excused in the cycle of a clear. The stimulus drives each fault source for exactly one cycle and keeps the clear and acknowledge pulses one cycle wide. It sweeps every pin against all eight combinations of cycle ownership and the two acknowledge lines, and it returns those control lines to idle before the request and stickiness checks.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int PROT_CPU_BIT  = 0;
  localparam int PROT_DMA_BIT  = 1;
  localparam int PLAIN_BASE    = 2;
endpackage

// File: rtl/fault_steer.sv
module fault_steer
  import fault_pkg::*;
#(
  parameter int N_PINS = 11,
  parameter int N_INT  = 4,
  parameter int FLAG_W = N_PINS + 1 + N_INT
) (
  input  logic [N_PINS-1:0] fault_pin_n,
  input  logic [N_INT-1:0]  int_fault,
  input  logic              dma_cycle,
  input  logic              dma_ack_n,
  input  logic              hold_ack_n,
  output logic [FLAG_W-1:0] set_vec
);
  logic prot_hit;
  assign prot_hit = ~fault_pin_n[0];

  // protection fault: owner steering, CPU flag blocked during DMA/hold grant
  assign set_vec[PROT_CPU_BIT] = prot_hit & ~dma_cycle & dma_ack_n & hold_ack_n;
  assign set_vec[PROT_DMA_BIT] = prot_hit & dma_cycle;

  for (genvar k = 1; k < N_PINS; k++) begin : g_pin
    assign set_vec[PLAIN_BASE + k - 1] = ~fault_pin_n[k];
  end

  for (genvar j = 0; j < N_INT; j++) begin : g_int
    assign set_vec[N_PINS + 1 + j] = int_fault[j];
  end
endmodule

// File: rtl/fault_store.sv
module fault_store #(
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [FLAG_W-1:0] set_vec,
  output logic [FLAG_W-1:0] fault_q
);
  always_ff @(posedge clk) begin
    if (rst)      fault_q <= '0;
    else if (clr) fault_q <= set_vec;           // same-cycle faults survive the clear
    else          fault_q <= fault_q | set_vec;
  end

  // R3: without a clear, no flag ever falls
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(clr) |-> ((fault_q & $past(fault_q)) == $past(fault_q)));
endmodule

// File: rtl/mce_oneshot.sv
module mce_oneshot (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic isr_clr,
  input  logic fault_nz,
  input  logic set0,
  input  logic held0,
  output logic req_q,
  output logic abort_n_q
);
  logic arm_q;
  logic fire;

  assign fire = arm_q & fault_nz & ~req_q & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q     <= 1'b1;
      req_q     <= 1'b0;
      abort_n_q <= 1'b1;
    end else begin
      if (clr)       arm_q <= 1'b1;
      else if (fire) arm_q <= 1'b0;
      req_q     <= fire | (req_q & ~isr_clr);
      abort_n_q <= ~(set0 & (~held0 | clr));
    end
  end

  // R6: a new request only follows a nonzero register
  a_r6_req_needs_fault: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> $past(fault_nz));

  // R9: abort pulse lasts one cycle outside a clear
  a_r9_abort_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !abort_n_q && !clr |=> abort_n_q);
endmodule

// File: rtl/fault_latch_unit.sv
module fault_latch_unit #(
  parameter int N_PINS = 11,
  parameter int N_INT  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_PINS-1:0]          fault_pin_n,
  input  logic [N_INT-1:0]           int_fault,
  input  logic                       dma_cycle,
  input  logic                       dma_ack_n,
  input  logic                       hold_ack_n,
  input  logic                       clr_faults,
  input  logic                       lvl1_clr,
  output logic [N_PINS+N_INT:0]      fault_reg,
  output logic                       lvl1_req,
  output logic                       abort_n
);
  localparam int FLAG_W = N_PINS + 1 + N_INT;

  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] fault_q;

  fault_steer #(.N_PINS(N_PINS), .N_INT(N_INT), .FLAG_W(FLAG_W)) steer_i (
    .fault_pin_n (fault_pin_n),
    .int_fault   (int_fault),
    .dma_cycle   (dma_cycle),
    .dma_ack_n   (dma_ack_n),
    .hold_ack_n  (hold_ack_n),
    .set_vec     (set_vec)
  );

  fault_store #(.FLAG_W(FLAG_W)) store_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_faults),
    .set_vec (set_vec),
    .fault_q (fault_q)
  );

  mce_oneshot shot_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_faults),
    .isr_clr   (lvl1_clr),
    .fault_nz  (|fault_q),
    .set0      (set_vec[0]),
    .held0     (fault_q[0]),
    .req_q     (lvl1_req),
    .abort_n_q (abort_n)
  );

  assign fault_reg = fault_q;

  // R5: CPU protection flag cannot be newly set under a DMA or hold grant
  a_r5_bit0_gated: assert property (@(posedge clk) disable iff (rst)
    (!dma_ack_n || !hold_ack_n) && !fault_reg[0] && !clr_faults |=> !fault_reg[0]);

  // R9: abort only appears together with a set bit 0
  a_r9_abort_with_bit0: assert property (@(posedge clk) disable iff (rst)
    !abort_n |-> fault_reg[0]);
endmodule

// File: tb/fault_latch_unit_tb_top.sv
module fault_latch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] fault_pin_n = '1;
  logic [3:0]  int_fault = '0;
  logic        dma_cycle = 1'b0;
  logic        dma_ack_n = 1'b1;
  logic        hold_ack_n = 1'b1;
  logic        clr_faults = 1'b0;
  logic        lvl1_clr = 1'b0;
  logic [15:0] fault_reg;
  logic        lvl1_req;
  logic        abort_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fault_latch_unit dut_i (
    .clk(clk), .rst(rst), .fault_pin_n(fault_pin_n), .int_fault(int_fault),
    .dma_cycle(dma_cycle), .dma_ack_n(dma_ack_n), .hold_ack_n(hold_ack_n),
    .clr_faults(clr_faults), .lvl1_clr(lvl1_clr),
    .fault_reg(fault_reg), .lvl1_req(lvl1_req), .abort_n(abort_n)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic clear_all;
    clr_faults = 1'b1; lvl1_clr = 1'b1;
    tick;
    clr_faults = 1'b0; lvl1_clr = 1'b0;
  endtask

  function automatic logic [15:0] expect_bits(int p, logic dc, logic da, logic ha);
    logic [15:0] e = '0;
    if (p == 0) begin
      if (dc) e[1] = 1'b1;
      else if (da && ha) e[0] = 1'b1;
    end else e[p+1] = 1'b1;
    return e;
  endfunction

  initial begin
    logic [15:0] e;
    tick; tick;
    chk(fault_reg, 16'h0, "R1 flags in reset");
    chk({15'd0, lvl1_req}, 16'd0, "R1 req in reset");
    chk({15'd0, abort_n}, 16'd1, "R1 abort in reset");
    rst = 1'b0;
    tick;
    chk(fault_reg, 16'h0, "R1 flags after reset");
    chk({15'd0, lvl1_req}, 16'd0, "R1 req after reset");

    // exhaustive sweep: every pin x ownership x acknowledge lines
    for (int p = 0; p < 11; p++) begin
      for (int m = 0; m < 8; m++) begin
        int q;
        clear_all;
        tick;
        e = expect_bits(p, m[0], m[1], m[2]);
        fault_pin_n[p] = 1'b0;
        dma_cycle = m[0]; dma_ack_n = m[1]; hold_ack_n = m[2];
        tick;
        fault_pin_n = '1; dma_cycle = 1'b0; dma_ack_n = 1'b1; hold_ack_n = 1'b1;
        chk(fault_reg, e, "R2 R4 R5 captured flags");
        chk({15'd0, abort_n}, {15'd0, ~e[0]}, "R9 abort on bit0");
        tick;
        chk(fault_reg, e, "R3 flags held");
        chk({15'd0, lvl1_req}, {15'd0, (e != 0)}, "R6 level-1 request");
        chk({15'd0, abort_n}, 16'd1, "R9 abort one cycle");
        if (e != 0) begin
          lvl1_clr = 1'b1;
          tick;
          lvl1_clr = 1'b0;
          chk({15'd0, lvl1_req}, 16'd0, "R6 request dropped by ack");
          q = (p == 3) ? 4 : 3;
          fault_pin_n[q] = 1'b0;
          tick;
          fault_pin_n = '1;
          chk(fault_reg, e | (16'h1 << (q + 1)), "R3 second fault adds");
          tick;
          chk({15'd0, lvl1_req}, 16'd0, "R7 no re-request before clear");
        end
      end
    end

    // internal sources
    for (int j = 0; j < 4; j++) begin
      clear_all;
      tick;
      int_fault[j] = 1'b1;
      tick;
      int_fault = '0;
      chk(fault_reg, 16'h1 << (12 + j), "R2 internal source");
      tick;
      chk({15'd0, lvl1_req}, 16'd1, "R6 internal source request");
    end

    // clear re-arms and a fault in the clear cycle survives
    lvl1_clr = 1'b1; tick; lvl1_clr = 1'b0;
    fault_pin_n[1] = 1'b0; clr_faults = 1'b1;
    tick;
    fault_pin_n = '1; clr_faults = 1'b0;
    chk(fault_reg, 16'h0004, "R8 same-cycle fault kept");
    tick;
    chk({15'd0, lvl1_req}, 16'd1, "R7 R8 request after clear");

    // abort does not repeat while bit0 already set
    clear_all;
    tick;
    fault_pin_n[0] = 1'b0;
    tick;
    fault_pin_n = '1;
    chk({15'd0, abort_n}, 16'd0, "R9 first bit0 abort");
    tick;
    fault_pin_n[0] = 1'b0;
    tick;
    fault_pin_n = '1;
    chk({15'd0, abort_n}, 16'd1, "R9 no abort when bit0 held");
    chk(fault_reg, 16'h0001, "R3 bit0 unchanged");
    fault_pin_n[5] = 1'b0;
    tick;
    fault_pin_n = '1;
    chk({15'd0, abort_n}, 16'd1, "R9 no abort for other bit");

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule